// File: doc/BRIEF.md
# I2C Slave Address Match and Acknowledge

This block watches a two-wire serial bus as a target and handles the first byte that follows every start or repeated start condition. It takes in eight bits on the rising edges of the clock line, most significant bit first. The upper seven bits are the address and the last bit is the transfer direction. The address is compared with a programmable own address. When it matches and acknowledging is enabled, the block pulls the data line low for the ninth clock. It raises a match flag and keeps the direction bit for the data phase that follows.

A byte whose address field is all zero and whose direction bit is zero is a general call. It has its own enable and its own flag. The clock and data lines arrive already synchronized to the system clock. Start and stop conditions arrive as one-cycle pulses from a detector outside the block. When the address is not acknowledged, the block releases the bus and ignores all traffic until the next start condition. Moving data after the address byte is left to other logic.

Top module: `i2c_addr_ack`

## Requirements
- R1: After reset, `sda_drive_low`, `addr_match`, `gen_call` and `rw_dir` are all 0.
- R2: Address bits are sampled from `sda_in` on rising edges of `scl_in`, most significant bit first. The first seven bits form the address and the eighth bit is the direction (1 = read, 0 = write).
- R3: An acknowledged address byte drives `sda_drive_low` to 1 (1 = pull the data line low). The drive begins one system clock after the falling edge of `scl_in` that ends the eighth bit. It ends one system clock after the falling edge that ends the ninth clock.
- R4: `addr_match` goes to 1 when the acknowledge begins for an own-address hit. It stays at 1 through the following data phase until the next start or stop pulse.
- R5: When an address is acknowledged, `rw_dir` takes the eighth bit of the byte. It keeps that value until the next start or stop pulse, and it is 0 when no address has been acknowledged.
- R6: An all-zero address field with direction bit 0 is a general call. It is acknowledged, with `gen_call` set to 1 and `addr_match` left at 0, only while `gc_ack_en` is 1. An all-zero address field with direction bit 1 is never acknowledged. A zero address field never counts as an own-address hit.
- R7: A nonzero address field equal to `own_addr` is acknowledged only while `ack_en` is 1. With `ack_en` at 0 the byte produces no drive and no flag.
- R8: After an address byte that is not acknowledged, further clock pulses produce no drive and no flag, even if they carry the own address, until a new start pulse.
- R9: A start pulse in the middle of a byte discards the partial address. The next eight bits are taken as a fresh address byte.
- R10: A stop pulse clears the partial address, both flags and `rw_dir`, and releases the data line. Clock pulses after it have no effect until a start pulse.
- R11: After the ninth clock of an acknowledged address, the data phase produces no further drive from this block until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| start_det | input | 1 | One-cycle pulse for a start or repeated start condition |
| stop_det | input | 1 | One-cycle pulse for a stop condition |
| own_addr | input | 7 | Programmed own address |
| ack_en | input | 1 | Enable acknowledge of the own address |
| gc_ack_en | input | 1 | Enable acknowledge of a general call |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| addr_match | output | 1 | Own address was acknowledged |
| gen_call | output | 1 | General call was acknowledged |
| rw_dir | output | 1 | Direction of the acknowledged transfer, 1 = read |

## Verification
The assertions rely on the upstream detector: start and stop pulses are never asserted in the same cycle, and they never coincide with an edge of `scl_in`. They also assume `sda_in` changes only while `scl_in` is low, so each sampled bit is stable. The stimulus holds every line level for several system clocks and raises each condition pulse for one cycle while the clock line is high and steady. The random traffic picks the address byte, own address and enables at random, but always keeps to this bus-legal order.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACK  = 2'd2,
    ST_PASS = 2'd3
  } am_state_t;

  function automatic logic [ADDR_W-1:0] addr_field(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction

  function automatic logic dir_bit(input logic [BYTE_W-1:0] b);
    return b[0];
  endfunction

  function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
    return (addr_field(b) == '0) && !dir_bit(b);
  endfunction

  function automatic logic own_hit(input logic [BYTE_W-1:0] b,
                                   input logic [ADDR_W-1:0] own);
    return (addr_field(b) != '0) && (addr_field(b) == own);
  endfunction

endpackage

// File: rtl/i2c_am_edge.sv
module i2c_am_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise,
  output logic fall
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_in;
  end

  assign rise = line_in && !line_q;
  assign fall = !line_in && line_q;
endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
  parameter int W = i2c_am_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         enable,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] data_o,
  output logic         full
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;

  assign full   = (cnt == CNT_FULL);
  assign data_o = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clear) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (enable && sample && !full) begin
      shreg <= {shreg[W-2:0], bit_in};
      cnt   <= cnt + 1'b1;
    end
  end

  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0) && (shreg == '0));
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              scl_fall,
  input  logic              byte_full,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              gc_ack_en,
  output am_state_t         state,
  output logic              pull_low,
  output logic              match_f,
  output logic              gcall_f,
  output logic              rw_f
);
  logic take_gc, take_own, decide;

  assign decide   = (state == ST_ADDR) && scl_fall && byte_full;
  assign take_gc  = is_gcall(rx_byte) && gc_ack_en;
  assign take_own = own_hit(rx_byte, own_addr) && ack_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pull_low <= 1'b0;
      match_f  <= 1'b0;
      gcall_f  <= 1'b0;
      rw_f     <= 1'b0;
    end else if (start_p || stop_p) begin
      state    <= start_p ? ST_ADDR : ST_IDLE;
      pull_low <= 1'b0;
      match_f  <= 1'b0;
      gcall_f  <= 1'b0;
      rw_f     <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (decide) begin
          if (take_gc || take_own) begin
            state    <= ST_ACK;
            pull_low <= 1'b1;
            gcall_f  <= take_gc;
            match_f  <= take_own;
            rw_f     <= dir_bit(rx_byte);
          end else begin
            state <= ST_PASS;
          end
        end
        ST_ACK: if (scl_fall) begin
          state    <= ST_PASS;
          pull_low <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_pull_begins_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> $past(scl_fall));

  assert_pull_ends_on_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low) |-> $past(scl_fall || start_p || stop_p));

  assert_pull_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (match_f || gcall_f));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_f && gcall_f));

  assert_gc_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_f) |-> $past(gc_ack_en));

  assert_match_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_f) |-> $past(ack_en));

  assert_dir_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_f || gcall_f) && !start_p && !stop_p) |=> $stable(rw_f));

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !pull_low && !match_f && !gcall_f && !rw_f);
endmodule

// File: rtl/i2c_addr_ack.sv
module i2c_addr_ack
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              gc_ack_en,
  output logic              sda_drive_low,
  output logic              addr_match,
  output logic              gen_call,
  output logic              rw_dir
);
  logic              scl_rise, scl_fall;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_full;
  am_state_t         state;

  i2c_am_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (scl_in),
    .rise    (scl_rise),
    .fall    (scl_fall)
  );

  i2c_am_shifter #(.W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_det || stop_det),
    .enable (state == ST_ADDR),
    .sample (scl_rise),
    .bit_in (sda_in),
    .data_o (rx_byte),
    .full   (byte_full)
  );

  i2c_am_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_p   (start_det),
    .stop_p    (stop_det),
    .scl_fall  (scl_fall),
    .byte_full (byte_full),
    .rx_byte   (rx_byte),
    .own_addr  (own_addr),
    .ack_en    (ack_en),
    .gc_ack_en (gc_ack_en),
    .state     (state),
    .pull_low  (sda_drive_low),
    .match_f   (addr_match),
    .gcall_f   (gen_call),
    .rw_f      (rw_dir)
  );

  assert_no_pull_outside_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !sda_drive_low) |=> !$rose(sda_drive_low));
endmodule

// File: tb/test_i2c_addr_ack.sv
module test_i2c_addr_ack;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, start_det = 1'b0, stop_det = 1'b0;
  logic [6:0] own_addr = 7'h35;
  logic ack_en = 1'b1, gc_ack_en = 1'b0;
  logic sda_drive_low, addr_match, gen_call, rw_dir;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_ack i_i2c_addr_ack (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det), .own_addr(own_addr),
    .ack_en(ack_en), .gc_ack_en(gc_ack_en), .sda_drive_low(sda_drive_low),
    .addr_match(addr_match), .gen_call(gen_call), .rw_dir(rw_dir)
  );

  // 0 = no ack, 1 = own address, 2 = general call
  function automatic int expect_kind(input logic [7:0] b, input logic [6:0] own,
                                     input logic ae, input logic ge);
    if (b[7:1] == 7'd0) return (b[0] == 1'b0 && ge) ? 2 : 0;
    if (b[7:1] == own && ae) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic do_start();
    sda_in = 1'b1; wait_ph();
    scl_in = 1'b1; wait_ph();
    sda_in = 1'b0; @(negedge clk);
    start_det = 1'b1; @(negedge clk);
    start_det = 1'b0; wait_ph();
    scl_in = 1'b0; wait_ph();
  endtask

  task automatic do_stop();
    sda_in = 1'b0; wait_ph();
    scl_in = 1'b1; wait_ph();
    sda_in = 1'b1; @(negedge clk);
    stop_det = 1'b1; @(negedge clk);
    stop_det = 1'b0; wait_ph();
  endtask

  task automatic clock_bit(input logic b);
    sda_in = b; wait_ph();
    scl_in = 1'b1; wait_ph();
    scl_in = 1'b0; wait_ph();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    check(req, "drive after 8th fall", sda_drive_low, exp_ack);
    sda_in = 1'b1; wait_ph();
    scl_in = 1'b1; wait_ph();
    check(req, "drive during 9th high", sda_drive_low, exp_ack);
    scl_in = 1'b0; wait_ph();
    check(req, "drive after 9th fall", sda_drive_low, 1'b0);
  endtask

  task automatic addr_phase(input logic [7:0] b, input string req);
    int k;
    k = expect_kind(b, own_addr, ack_en, gc_ack_en);
    do_start();
    send_byte(b, k != 0, req);
    check(req, "addr_match", addr_match, k == 1);
    check(req, "gen_call", gen_call, k == 2);
    check(req, "rw_dir", rw_dir, (k != 0) ? b[0] : 1'b0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "drive", sda_drive_low, 1'b0);
    check("R1", "flags", {addr_match, gen_call, rw_dir}, 3'b000);
    rst_n = 1'b1;
    wait_ph();

    // R3 R4 R5: own address write then read
    own_addr = 7'h35; ack_en = 1'b1; gc_ack_en = 1'b0;
    addr_phase({7'h35, 1'b0}, "R3");
    addr_phase({7'h35, 1'b1}, "R5");
    // R11 R4: data phase byte carrying own address, no drive, flag held
    send_byte({7'h35, 1'b1}, 1'b0, "R11");
    check("R4", "match held in data phase", addr_match, 1'b1);
    check("R5", "rw held in data phase", rw_dir, 1'b1);
    // R10: stop clears flags
    do_stop();
    check("R10", "flags after stop", {addr_match, gen_call, rw_dir}, 3'b000);
    check("R10", "drive after stop", sda_drive_low, 1'b0);
    send_byte({7'h35, 1'b0}, 1'b0, "R10");
    check("R10", "no match without start", addr_match, 1'b0);

    // R2: bit-reversed own address must not match
    addr_phase({7'h56, 1'b0}, "R2");
    addr_phase({7'h35, 1'b0}, "R2");

    // R8: mismatch then own address without start
    addr_phase({7'h12, 1'b0}, "R8");
    send_byte({7'h35, 1'b0}, 1'b0, "R8");
    check("R8", "flag stays clear", addr_match, 1'b0);

    // R6 general call
    gc_ack_en = 1'b1;
    addr_phase(8'h00, "R6");
    addr_phase(8'h01, "R6");
    gc_ack_en = 1'b0;
    addr_phase(8'h00, "R6");
    own_addr = 7'h00; gc_ack_en = 1'b0;
    addr_phase(8'h01, "R6");
    own_addr = 7'h35;

    // R7: own address with ack disabled
    ack_en = 1'b0;
    addr_phase({7'h35, 1'b0}, "R7");
    ack_en = 1'b1;

    // R9: start mid-byte then fresh address
    do_start();
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
    do_start();
    send_byte({7'h35, 1'b1}, 1'b1, "R9");
    check("R9", "match after restart", addr_match, 1'b1);
    check("R9", "rw after restart", rw_dir, 1'b1);

    // R10: stop mid-byte then clocks
    do_start();
    clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b1);
    do_stop();
    send_byte({7'h35, 1'b0}, 1'b0, "R10");

    // random traffic
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      own_addr  = 7'($urandom);
      ack_en    = 1'($urandom);
      gc_ack_en = 1'($urandom);
      b = 8'($urandom);
      case ($urandom % 4)
        0, 1: b[7:1] = own_addr;
        2:    b[7:1] = 7'd0;
        default: ;
      endcase
      addr_phase(b, "R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule